// File: doc/BRIEF.md
# Saturating Element Add/Subtract Unit

This unit adds or subtracts one pair of integer elements per clock. Each operand is read at a source element width of 8, 16 or 32 bits. The unit then delivers a result at a destination element width that may differ from the source width. With saturation enabled, a result that falls outside the destination range is pinned to the nearest bound. The range is unsigned or two's-complement, chosen per element. With saturation off, the result simply keeps its low destination bits.

Every element may also produce its own 4-bit condition field. The field holds less-than, greater-than and equal flags taken from the final result, plus an overflow flag that is set only when clamping happened. There is no accumulated or shared flag: one element's flags never affect another's. An operation marked as carry-producing cannot be combined with saturation. That pairing is rejected, and nothing is written for it.

Results, write enables and flags appear one clock after the element is presented.

Top module: `elw_sat_alu`

## Requirements
- R1: With `sat_i`=1 and `signed_i`=0, the result is clamped to 0 .. 2^d-1, where d is the destination width.
- R2: With `sat_i`=1 and `signed_i`=1, the result is clamped to -2^(d-1) .. 2^(d-1)-1.
- R3: Operands come from the low source-width bits of `a_i`/`b_i` and are extended by `signed_i`. The sum or difference is formed exactly, with no wrap at the source width, before it is clamped or truncated to the destination width.
- R4: `cr_we_o` is 1 only for a legal element that had `rec_i`=1. Bit 0 of `cr_o` (overflow) is 1 exactly when clamping altered the result, so it is always 0 with `sat_i`=0.
- R5: `cr_o` is {lt, gt, eq, ov} with lt in bit 3. Exactly one of lt, gt and eq is set, judged from the final result in the selected signedness. lt is never set for unsigned elements.
- R6: `carry_op_i`=1 together with `sat_i`=1 raises `illegal_o` and leaves both write enables low. A carry operation without saturation behaves as a plain wrapping operation.
- R7: The width codes are 2'b00 = 8 bits, 2'b01 = 16 bits and 2'b10 = 32 bits. Code 2'b11 is treated as 32 bits.
- R8: Outputs are registered with one cycle of latency. The write enables and `illegal_o` are 0 when `valid_i` was 0. All outputs are 0 after reset.
- R9: With `sat_i`=0, the result is the low d bits of the exact result.
- R10: `res_o` is the d-bit result sign-extended to 32 bits when `signed_i`=1 and zero-extended when `signed_i`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Element present this cycle |
| sub_i | input | 1 | 1 = subtract b from a, 0 = add |
| carry_op_i | input | 1 | Operation is of the carry-producing kind |
| signed_i | input | 1 | Signed interpretation and signed clamp range |
| sat_i | input | 1 | Saturation enable |
| rec_i | input | 1 | Record the condition field |
| src_w_i | input | 2 | Source element width code |
| dst_w_i | input | 2 | Destination element width code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| res_we_o | output | 1 | Result write enable |
| cr_we_o | output | 1 | Condition field write enable |
| illegal_o | output | 1 | Saturation requested on a carry operation |
| res_o | output | 32 | Extended destination-width result |
| cr_o | output | 4 | Condition field {lt, gt, eq, ov} |

## Verification
The properties assume that the control inputs are steady around each rising edge, so that each output can be matched against the values sampled one cycle earlier. They also assume that the operand bits above the source width carry no meaning. The stimulus changes inputs only on falling edges. It fills the unused upper operand bits with random data, which shows that those bits are ignored. It mixes directed edge values with random elements across every width code, including the reserved one.

// File: rtl/elw_pkg.sv
package elw_pkg;
  typedef enum logic [1:0] {EW_8 = 2'b00, EW_16 = 2'b01, EW_32 = 2'b10, EW_RSV = 2'b11} ew_e;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic ov;
  } cond_t;

  function automatic int unsigned ew_bits(input logic [1:0] code);
    case (code)
      2'b00:   return 8;
      2'b01:   return 16;
      default: return 32;
    endcase
  endfunction
endpackage

// File: rtl/elw_opnd_ext.sv
module elw_opnd_ext #(
  parameter int DATA_W = 32,
  parameter int CALC_W = DATA_W + 2
) (
  input  logic [DATA_W-1:0]        raw_i,
  input  logic [1:0]               src_w_i,
  input  logic                     signed_i,
  output logic signed [CALC_W-1:0] ext_o
);
  logic sgn;

  always_comb begin
    case (src_w_i)
      2'b00: begin
        sgn   = signed_i & raw_i[7];
        ext_o = {{(CALC_W-8){sgn}}, raw_i[7:0]};
      end
      2'b01: begin
        sgn   = signed_i & raw_i[15];
        ext_o = {{(CALC_W-16){sgn}}, raw_i[15:0]};
      end
      default: begin
        sgn   = signed_i & raw_i[DATA_W-1];
        ext_o = {{(CALC_W-DATA_W){sgn}}, raw_i};
      end
    endcase
  end
endmodule

// File: rtl/elw_clamp.sv
module elw_clamp
  import elw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CALC_W = DATA_W + 2
) (
  input  logic signed [CALC_W-1:0] sum_i,
  input  logic [1:0]               dst_w_i,
  input  logic                     signed_i,
  input  logic                     sat_i,
  output logic [DATA_W-1:0]        res_o,
  output logic                     ov_o
);
  logic signed [CALC_W-1:0] one_s, hi, lo;
  logic                     over, under;
  logic [DATA_W-1:0]        val;
  int unsigned              d;

  always_comb begin
    d     = ew_bits(dst_w_i);
    one_s = CALC_W'(1);
    if (signed_i) begin
      hi = (one_s <<< (d - 1)) - one_s;
      lo = -(one_s <<< (d - 1));
    end else begin
      hi = (one_s <<< d) - one_s;
      lo = '0;
    end
    over  = sum_i > hi;
    under = sum_i < lo;
    ov_o  = sat_i & (over | under);
    // clamp only when enabled, else keep exact low bits
    val = (sat_i & over)  ? hi[DATA_W-1:0] :
          (sat_i & under) ? lo[DATA_W-1:0] : sum_i[DATA_W-1:0];
    case (dst_w_i)
      2'b00:   res_o = {{(DATA_W-8){signed_i & val[7]}}, val[7:0]};
      2'b01:   res_o = {{(DATA_W-16){signed_i & val[15]}}, val[15:0]};
      default: res_o = val;
    endcase
  end
endmodule

// File: rtl/elw_cond.sv
module elw_cond
  import elw_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] res_i,
  input  logic              signed_i,
  input  logic              ov_i,
  output cond_t             cond_o
);
  always_comb begin
    cond_o.eq = (res_i == '0);
    cond_o.lt = signed_i & res_i[DATA_W-1];
    cond_o.gt = ~cond_o.eq & ~cond_o.lt;
    cond_o.ov = ov_i;
  end
endmodule

// File: rtl/elw_sat_alu.sv
module elw_sat_alu
  import elw_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              sub_i,
  input  logic              carry_op_i,
  input  logic              signed_i,
  input  logic              sat_i,
  input  logic              rec_i,
  input  logic [1:0]        src_w_i,
  input  logic [1:0]        dst_w_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              res_we_o,
  output logic              cr_we_o,
  output logic              illegal_o,
  output logic [DATA_W-1:0] res_o,
  output logic [3:0]        cr_o
);
  localparam int CALC_W = DATA_W + 2;
  localparam int N_OPND = 2;

  logic [DATA_W-1:0]        raw   [N_OPND];
  logic signed [CALC_W-1:0] ext_v [N_OPND];
  logic signed [CALC_W-1:0] sum;
  logic [DATA_W-1:0]        res_d;
  logic                     ov_d, bad, wr;
  cond_t                    cond_d;

  assign raw[0] = a_i;
  assign raw[1] = b_i;

  for (genvar g = 0; g < N_OPND; g++) begin : g_ext
    elw_opnd_ext #(.DATA_W(DATA_W), .CALC_W(CALC_W)) u_ext (
      .raw_i   (raw[g]),
      .src_w_i (src_w_i),
      .signed_i(signed_i),
      .ext_o   (ext_v[g])
    );
  end

  // exact result; carry-kind ops without saturation just wrap
  assign sum = sub_i ? (ext_v[0] - ext_v[1]) : (ext_v[0] + ext_v[1]);

  elw_clamp #(.DATA_W(DATA_W), .CALC_W(CALC_W)) u_clamp (
    .sum_i   (sum),
    .dst_w_i (dst_w_i),
    .signed_i(signed_i),
    .sat_i   (sat_i),
    .res_o   (res_d),
    .ov_o    (ov_d)
  );

  elw_cond #(.DATA_W(DATA_W)) u_cond (
    .res_i   (res_d),
    .signed_i(signed_i),
    .ov_i    (ov_d),
    .cond_o  (cond_d)
  );

  assign bad = valid_i & carry_op_i & sat_i;
  assign wr  = valid_i & ~bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_we_o  <= 1'b0;
      cr_we_o   <= 1'b0;
      illegal_o <= 1'b0;
      res_o     <= '0;
      cr_o      <= '0;
    end else begin
      res_we_o  <= wr;
      cr_we_o   <= wr & rec_i;
      illegal_o <= bad;
      if (wr) res_o <= res_d;
      if (wr & rec_i) cr_o <= cond_d;
    end
  end
endmodule

// File: rtl/elw_sat_alu_chk.sv
module elw_sat_alu_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              carry_op_i,
  input logic              signed_i,
  input logic              sat_i,
  input logic              rec_i,
  input logic [1:0]        dst_w_i,
  input logic              res_we_o,
  input logic              cr_we_o,
  input logic              illegal_o,
  input logic [DATA_W-1:0] res_o,
  input logic [3:0]        cr_o
);
  assert_illegal_no_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!res_we_o && !cr_we_o));

  assert_illegal_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> $past(carry_op_i && sat_i));

  assert_cr_we_rec_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_we_o |-> $past(rec_i && valid_i));

  assert_ov_needs_sat_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cr_we_o && cr_o[0]) |-> $past(sat_i));

  assert_one_relation_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_we_o |-> ($countones(cr_o[3:1]) == 1));

  assert_unsigned_no_lt_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cr_we_o && !$past(signed_i)) |-> !cr_o[3]);

  assert_latency_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_we_o || illegal_o) |-> $past(valid_i));

  assert_u8_zero_ext_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_we_o && !$past(signed_i) && $past(dst_w_i) == 2'b00) |-> (res_o[DATA_W-1:8] == '0));
endmodule

bind elw_sat_alu elw_sat_alu_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_elw_sat_alu.sv
`timescale 1ns/1ps
module sim_elw_sat_alu;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 0, sub_i = 0, carry_op_i = 0, signed_i = 0, sat_i = 0, rec_i = 0;
  logic [1:0]  src_w_i = 0, dst_w_i = 0;
  logic [31:0] a_i = 0, b_i = 0;
  logic        res_we_o, cr_we_o, illegal_o;
  logic [31:0] res_o;
  logic [3:0]  cr_o;

  int checks = 0, fails = 0;
  bit e_res_we = 0, e_cr_we = 0, e_ill = 0;
  logic [31:0] e_res = 0;
  logic [3:0]  e_cr = 0;
  string e_tag = "R8";

  always #2 clk_i = ~clk_i;

  elw_sat_alu u0 (.*);

  task automatic chk(input string tag, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk("R8 res_we", res_we_o == e_res_we, res_we_o, e_res_we);
    chk("R4 cr_we", cr_we_o == e_cr_we, cr_we_o, e_cr_we);
    chk("R6 illegal", illegal_o == e_ill, illegal_o, e_ill);
    if (e_res_we) chk({e_tag, " res"}, res_o == e_res, res_o, e_res);
    if (e_cr_we)  chk("R5 cond", cr_o == e_cr, cr_o, e_cr);
  endtask

  function automatic int wbits(input logic [1:0] c);
    return (c == 2'b00) ? 8 : (c == 2'b01) ? 16 : 32;
  endfunction

  function automatic longint rd(input logic [31:0] v, input int w, input bit sg);
    longint x = longint'(v) & ((64'sd1 <<< w) - 1);
    if (sg && x[w-1]) x = x - (64'sd1 <<< w);
    return x;
  endfunction

  task automatic elem(input bit vld, input bit sb, input bit cy, input bit sg, input bit st,
                      input bit rc, input logic [1:0] sw, input logic [1:0] dw,
                      input logic [31:0] a, input logic [31:0] b, input string tag);
    longint ex, lo, hi, f;
    int d;
    bit ov;
    @(negedge clk_i);
    compare();
    valid_i = vld; sub_i = sb; carry_op_i = cy; signed_i = sg; sat_i = st; rec_i = rc;
    src_w_i = sw; dst_w_i = dw; a_i = a; b_i = b;
    d  = wbits(dw);
    ex = sb ? rd(a, wbits(sw), sg) - rd(b, wbits(sw), sg) : rd(a, wbits(sw), sg) + rd(b, wbits(sw), sg);
    lo = sg ? -(64'sd1 <<< (d-1)) : 0;
    hi = sg ? (64'sd1 <<< (d-1)) - 1 : (64'sd1 <<< d) - 1;
    ov = 0;
    if (st && ex > hi) begin f = hi; ov = 1; end
    else if (st && ex < lo) begin f = lo; ov = 1; end
    else f = rd(ex[31:0], d, sg);
    e_ill    = vld && cy && st;
    e_res_we = vld && !e_ill;
    e_cr_we  = e_res_we && rc;
    if (e_res_we) e_res = f[31:0];
    if (e_cr_we)  e_cr = {f < 0, f > 0, f == 0, ov};
    if (tag != "") e_tag = tag;
    else e_tag = !st ? "R9" : sg ? "R2" : "R1";
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R8 reset res", res_o == 0, res_o, 0);
    chk("R8 reset cr", cr_o == 0, cr_o, 0);
    rst_ni = 1'b1;
    // R1 unsigned clamp high and low
    elem(1,0,0,0,1,1,2'b00,2'b00,32'hAB00_00C8,32'h0000_0064,"R1");
    elem(1,1,0,0,1,1,2'b00,2'b00,32'd10,32'd20,"R1");
    // R2 signed clamp both ends, 8 and 16 bit
    elem(1,0,0,1,1,1,2'b00,2'b00,32'd100,32'd100,"R2");
    elem(1,0,0,1,1,1,2'b00,2'b00,32'hFFFF_FF9C,32'h0000_009C,"R2");
    elem(1,0,0,1,1,1,2'b01,2'b01,32'h7000,32'h1000,"R2");
    // R3 wider destination: no clamp; narrower destination: clamp
    elem(1,0,0,0,1,1,2'b00,2'b01,32'd200,32'd100,"R3");
    elem(1,0,0,0,1,1,2'b10,2'b00,32'h100,32'd0,"R3");
    elem(1,0,0,1,1,1,2'b00,2'b10,32'h80,32'h80,"R3");
    // R9 wrap without saturation
    elem(1,0,0,0,0,1,2'b00,2'b00,32'd200,32'd100,"R9");
    // R6 carry with and without saturation
    elem(1,0,1,0,1,1,2'b10,2'b10,32'd5,32'd6,"R6");
    elem(1,0,1,0,0,1,2'b10,2'b10,32'hFFFF_FFFF,32'd2,"R6");
    // R7 reserved width code acts as 32
    elem(1,0,0,0,1,1,2'b11,2'b11,32'hFFFF_FFFF,32'd1,"R7");
    elem(1,0,0,0,0,1,2'b01,2'b11,32'h1234_FFFF,32'd1,"R7");
    // R4 no record: flags not written
    elem(1,0,0,0,1,0,2'b00,2'b00,32'd250,32'd10,"R4");
    // R10 sign extension of an 8-bit result
    elem(1,0,0,1,0,1,2'b00,2'b00,32'h7F,32'h01,"R10");
    // R5 equal result
    elem(1,1,0,1,1,1,2'b01,2'b01,32'h1234,32'h1234,"R5");
    // R8 idle cycle
    elem(0,0,0,0,1,1,2'b00,2'b00,32'd1,32'd1,"R8");
    for (int i = 0; i < 600; i++)
      elem($urandom_range(0,7) != 0, $urandom_range(0,1), $urandom_range(0,7) == 0,
           $urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,1),
           2'($urandom_range(0,3)), 2'($urandom_range(0,3)), $urandom, $urandom, "");
    elem(0,0,0,0,0,0,2'b00,2'b00,32'd0,32'd0,"R8");
    @(negedge clk_i);
    compare();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule